// File: doc/BRIEF.md
# Multi-Channel Sample Receive Buffer

This block gathers 24-bit samples from up to four decimated audio channels into one shared first-in first-out store and hands them to software or a DMA engine through a single holding register. Each word leaving the holding register carries the index of the channel that produced it in its top byte, so one reader can sort an interleaved stream without side information. When several channels deliver a sample in the same cycle, all of them are stored in that cycle, lowest channel index first.

Alongside the data path the block keeps a small interrupt register set: a write-one-to-set enable register, a write-one-to-clear disable register, a read-only view of the resulting mask and a status register. Four status bits follow the fill level live; the underrun and overrun bits are latched and cleared by reading the status register. A programmable chunk size (1, 2, 4 or 8 words) drives both a status bit and a DMA request line, so a DMA channel can be set up for bursts of exactly that many words. The store depth must be a power of two.

Top module: `mic_rx_fifo`

## Requirements
- R1: After reset the store is empty, the mask is zero, `irqOut` and `dmaReq` are low, the chunk size is 1 and the status register reads 0x02.
- R2: Register offsets are mode 0x04, holding 0x0C, enable 0x14, disable 0x18, mask 0x1C, status 0x20, version 0x50; reading any other offset returns 0. Read data appears on `regRdData` the cycle after `regRdEn` is sampled and then holds.
- R3: Writing ones to offset 0x14 sets the matching mask bits, writing ones to 0x18 clears them, other mask bits are untouched, and writes to the mask view at 0x1C have no effect.
- R4: Status bit positions are: bit 0 data ready (at least one word stored), bit 1 empty, bit 2 full, bit 3 chunk ready, bit 4 underrun, bit 5 overrun; bits 0 to 3 follow the current fill level.
- R5: A holding-register read returns the oldest word as {channel index in bits 31:24, sample in bits 23:0} and removes it.
- R6: Samples that arrive in the same cycle are stored in ascending channel order; words leave in arrival order.
- R7: The store holds 16 words; 16 consecutive holding reads after 16 stores drain it to empty.
- R8: A sample that finds no free entry is dropped and sets the overrun flag; in a cycle with partial room the lowest channels are kept.
- R9: A holding read while empty returns 0, changes nothing in the store and sets the underrun flag.
- R10: A status read returns the flags as they stood before the read and then clears underrun and overrun.
- R11: The chunk size is the field in mode bits 31:28 (read back as written); values 1, 2, 4 and 8 select that many words and any other value acts as 1. Chunk ready and `dmaReq` are high exactly while the fill level is at least the chunk size.
- R12: `irqOut` is high exactly while some status bit and its mask bit are both set.
- R13: The version register returns the 12-bit `VERSION` parameter in bits 11:0 and zero above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | NCH | One strobe per channel, sample present this cycle |
| sampleData | input | NCH*SAMPLE_W | Channel samples, channel i in slice i |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 32 | Registered read data |
| irqOut | output | 1 | Level interrupt request |
| dmaReq | output | 1 | Chunk-sized DMA request |

## Verification
The bench builds the block with its defaults: four channels, 24-bit samples and a 16-word store. With four channels able to push at once, the full store is reached in four cycles, which puts a same-cycle arrival with room for only two samples within reach, as well as the ordering of sparse channel sets. The 16-word depth makes the full drain and the 8-word chunk threshold reachable by short directed sequences.

// File: rtl/mic_rx_pkg.sv
package mic_rx_pkg;

  localparam int WORD_W = 32;
  localparam int STS_W  = 6;

  localparam logic [7:0] ADDR_MODE = 8'h04;
  localparam logic [7:0] ADDR_HOLD = 8'h0C;
  localparam logic [7:0] ADDR_IEN  = 8'h14;
  localparam logic [7:0] ADDR_IDIS = 8'h18;
  localparam logic [7:0] ADDR_IMSK = 8'h1C;
  localparam logic [7:0] ADDR_ISTS = 8'h20;
  localparam logic [7:0] ADDR_VER  = 8'h50;

  localparam int STS_READY = 0;
  localparam int STS_EMPTY = 1;
  localparam int STS_FULL  = 2;
  localparam int STS_CHUNK = 3;
  localparam int STS_UDR   = 4;
  localparam int STS_OVR   = 5;

  typedef struct packed {
    logic pop;
  } ctrlStrobe_t;

  typedef struct packed {
    logic underrun;
    logic overrun;
  } fifoEvent_t;

endpackage

// File: rtl/mic_rx_datapath.sv
module mic_rx_datapath
  import mic_rx_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int SAMPLE_W = 24,
  parameter int DEPTH    = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NCH-1:0]            sampleValid,
  input  logic [NCH*SAMPLE_W-1:0]   sampleData,
  input  ctrlStrobe_t               strobe,
  output logic [WORD_W-1:0]         headWord,
  output logic [$clog2(DEPTH):0]    fillCount,
  output fifoEvent_t                events
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int TAG_W = WORD_W - SAMPLE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  room, pushCnt;
  logic [CNT_W-1:0]  slotIdx [NCH];
  logic [NCH-1:0]    accept;
  logic              doPop;

  assign room  = CNT_W'(DEPTH) - fillCount;
  assign doPop = strobe.pop && (fillCount != '0);

  // Slot assignment: lower channels take the earlier free entries.
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc     = '0;
    pushCnt = '0;
    accept  = '0;
    for (int i = 0; i < NCH; i++) begin
      slotIdx[i] = acc;
      if (sampleValid[i]) begin
        if (acc < room) begin
          accept[i] = 1'b1;
          pushCnt   = pushCnt + 1'b1;
        end
        acc = acc + 1'b1;
      end
    end
  end

  assign events.overrun  = |(sampleValid & ~accept);
  assign events.underrun = strobe.pop && (fillCount == '0);
  assign headWord        = mem[rdPtr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (accept[i]) begin
        mem[wrPtr + slotIdx[i][PTR_W-1:0]] <=
          {TAG_W'(i), sampleData[i*SAMPLE_W +: SAMPLE_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      wrPtr     <= wrPtr + PTR_W'(pushCnt);
      rdPtr     <= rdPtr + PTR_W'(doPop);
      fillCount <= fillCount + pushCnt - CNT_W'(doPop);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH)); // R7

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == CNT_W'(DEPTH) && |sampleValid) |-> events.overrun); // R8

  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0 && strobe.pop && !(|sampleValid)) |=> fillCount == '0); // R9

endmodule

// File: rtl/mic_rx_ctrl.sv
module mic_rx_ctrl
  import mic_rx_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter logic [11:0] VERSION = 12'h2B7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              regAddr,
  input  logic                    regWrEn,
  input  logic [WORD_W-1:0]       regWrData,
  input  logic                    regRdEn,
  output logic [WORD_W-1:0]       regRdData,
  input  logic [$clog2(DEPTH):0]  fillCount,
  input  logic [WORD_W-1:0]       headWord,
  input  fifoEvent_t              events,
  output ctrlStrobe_t             strobe,
  output logic                    irqOut,
  output logic                    dmaReq
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [STS_W-1:0]  maskReg;
  logic              udrFlag, ovrFlag;
  logic [3:0]        chunkField, chunkThr;
  logic              fifoEmpty, fifoFull, chunkRdy, stsRead;
  logic [STS_W-1:0]  statusNow;
  logic [WORD_W-1:0] readMux;

  assign strobe.pop = regRdEn && (regAddr == ADDR_HOLD);
  assign stsRead    = regRdEn && (regAddr == ADDR_ISTS);

  always_comb begin
    case (chunkField)
      4'd2:    chunkThr = 4'd2;
      4'd4:    chunkThr = 4'd4;
      4'd8:    chunkThr = 4'd8;
      default: chunkThr = 4'd1;
    endcase
  end

  assign fifoEmpty = (fillCount == '0);
  assign fifoFull  = (fillCount == CNT_W'(DEPTH));
  assign chunkRdy  = int'(fillCount) >= int'(chunkThr);

  always_comb begin
    statusNow            = '0;
    statusNow[STS_READY] = !fifoEmpty;
    statusNow[STS_EMPTY] = fifoEmpty;
    statusNow[STS_FULL]  = fifoFull;
    statusNow[STS_CHUNK] = chunkRdy;
    statusNow[STS_UDR]   = udrFlag;
    statusNow[STS_OVR]   = ovrFlag;
  end

  assign irqOut = |(statusNow & maskReg);
  assign dmaReq = chunkRdy;

  always_comb begin
    case (regAddr)
      ADDR_MODE: readMux = {chunkField, 28'd0};
      ADDR_HOLD: readMux = fifoEmpty ? '0 : headWord;
      ADDR_IMSK: readMux = {{(WORD_W-STS_W){1'b0}}, maskReg};
      ADDR_ISTS: readMux = {{(WORD_W-STS_W){1'b0}}, statusNow};
      ADDR_VER:  readMux = {20'd0, VERSION};
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg    <= '0;
      udrFlag    <= 1'b0;
      ovrFlag    <= 1'b0;
      chunkField <= 4'd1;
      regRdData  <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          ADDR_MODE: chunkField <= regWrData[31:28];
          ADDR_IEN:  maskReg    <= maskReg | regWrData[STS_W-1:0];
          ADDR_IDIS: maskReg    <= maskReg & ~regWrData[STS_W-1:0];
          default:   ;
        endcase
      end
      // A new event in the same cycle as a status read wins over the clear.
      if (events.underrun)  udrFlag <= 1'b1;
      else if (stsRead)     udrFlag <= 1'b0;
      if (events.overrun)   ovrFlag <= 1'b1;
      else if (stsRead)     ovrFlag <= 1'b0;
      if (regRdEn) regRdData <= readMux;
    end
  end

  AST_IEN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_IEN) |=>
      ((maskReg & $past(regWrData[STS_W-1:0])) == $past(regWrData[STS_W-1:0]))); // R3

  AST_IDIS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_IDIS) |=>
      ((maskReg & $past(regWrData[STS_W-1:0])) == '0)); // R3

  AST_UDR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && fillCount == '0) |=> udrFlag); // R9

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !stsRead) |=> ovrFlag); // R10

  AST_DMA_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> fillCount != '0); // R11

endmodule

// File: rtl/mic_rx_fifo.sv
module mic_rx_fifo
  import mic_rx_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter int          SAMPLE_W = 24,
  parameter int          DEPTH    = 16,
  parameter logic [11:0] VERSION  = 12'h2B7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NCH-1:0]          sampleValid,
  input  logic [NCH*SAMPLE_W-1:0] sampleData,
  input  logic [7:0]              regAddr,
  input  logic                    regWrEn,
  input  logic [31:0]             regWrData,
  input  logic                    regRdEn,
  output logic [31:0]             regRdData,
  output logic                    irqOut,
  output logic                    dmaReq
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  ctrlStrobe_t       strobe;
  fifoEvent_t        events;
  logic [WORD_W-1:0] headWord;
  logic [CNT_W-1:0]  fillCount;

  mic_rx_datapath #(
    .NCH(NCH), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .strobe(strobe), .headWord(headWord),
    .fillCount(fillCount), .events(events)
  );

  mic_rx_ctrl #(
    .DEPTH(DEPTH), .VERSION(VERSION)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData),
    .fillCount(fillCount), .headWord(headWord), .events(events),
    .strobe(strobe), .irqOut(irqOut), .dmaReq(dmaReq)
  );

endmodule

// File: tb/mic_rx_fifo_tb.sv
module mic_rx_fifo_tb;

  localparam int          NCH = 4;
  localparam int          SW  = 24;
  localparam logic [11:0] VER = 12'h2B7;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCH-1:0]  sampleValid = '0;
  logic [NCH*SW-1:0] sampleData = '0;
  logic [7:0]      regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [31:0]     regWrData = '0;
  logic            regRdEn = 1'b0;
  logic [31:0]     regRdData;
  logic            irqOut, dmaReq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mic_rx_fifo #(.NCH(NCH), .SAMPLE_W(SW), .DEPTH(16), .VERSION(VER)) u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic push(input logic [NCH-1:0] v, input logic [23:0] base);
    sampleValid = v;
    for (int i = 0; i < NCH; i++) sampleData[i*SW +: SW] = base + 24'(i);
    @(posedge clk); @(negedge clk);
    sampleValid = '0;
  endtask

  function automatic logic [31:0] word(input int ch, input logic [23:0] base);
    return {8'(ch), base + 24'(ch)};
  endfunction

  task automatic testReset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    check("R1 dmaReq", {31'd0, dmaReq}, 32'd0);
    readReg(8'h20, d); check("R1 status", d, 32'h02);
    readReg(8'h1C, d); check("R1 mask", d, 32'h0);
    readReg(8'h04, d); check("R1 chunk", d, 32'h1000_0000);
  endtask

  task automatic testVersion();
    logic [31:0] d;
    readReg(8'h50, d); check("R13 version", d, {20'd0, VER});
    readReg(8'h40, d); check("R2 unmapped", d, 32'd0);
    @(negedge clk); check("R2 read data holds", regRdData, 32'd0);
  endtask

  task automatic testMask();
    logic [31:0] d;
    writeReg(8'h14, 32'h3F);
    writeReg(8'h18, 32'h0A);
    readReg(8'h1C, d); check("R3 set/clear", d, 32'h35);
    writeReg(8'h1C, 32'hFF);
    readReg(8'h1C, d); check("R3 mask view read-only", d, 32'h35);
    writeReg(8'h18, 32'h3F);
    readReg(8'h1C, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic testOrder();
    logic [31:0] d;
    push(4'hF, 24'h100);
    readReg(8'h20, d); check("R4 ready+chunk", d, 32'h09);
    for (int i = 0; i < 4; i++) begin
      readReg(8'h0C, d); check("R5 R6 same-cycle order", d, word(i, 24'h100));
    end
    push(4'b1010, 24'h200);
    push(4'b0001, 24'h300);
    readReg(8'h0C, d); check("R6 sparse ch1", d, word(1, 24'h200));
    readReg(8'h0C, d); check("R6 sparse ch3", d, word(3, 24'h200));
    readReg(8'h0C, d); check("R6 later ch0", d, word(0, 24'h300));
    readReg(8'h20, d); check("R4 empty again", d, 32'h02);
  endtask

  task automatic testFullOverrun();
    logic [31:0] d;
    for (int c = 0; c < 4; c++) push(4'hF, 24'h1000 + 24'(c * 16));
    push(4'b0100, 24'h9000);
    readReg(8'h20, d); check("R8 R4 full with overrun", d, 32'h2D);
    readReg(8'h20, d); check("R10 status read clears", d, 32'h0D);
    for (int k = 0; k < 16; k++) begin
      readReg(8'h0C, d);
      check("R7 drain", d, word(k % 4, 24'h1000 + 24'((k / 4) * 16)));
    end
    readReg(8'h20, d); check("R7 empty after 16 reads", d, 32'h02);
  endtask

  task automatic testPartial();
    logic [31:0] d;
    for (int c = 0; c < 3; c++) push(4'hF, 24'h2000 + 24'(c * 16));
    push(4'b0011, 24'h2300);
    push(4'hF, 24'h2400);
    readReg(8'h20, d); check("R8 partial room overrun", d, 32'h2D);
    for (int k = 0; k < 14; k++) readReg(8'h0C, d);
    readReg(8'h0C, d); check("R8 kept ch0", d, word(0, 24'h2400));
    readReg(8'h0C, d); check("R8 kept ch1", d, word(1, 24'h2400));
    readReg(8'h20, d); check("R8 dropped rest", d, 32'h02);
  endtask

  task automatic testUnderrun();
    logic [31:0] d;
    readReg(8'h0C, d); check("R9 empty read returns 0", d, 32'd0);
    readReg(8'h20, d); check("R9 underrun flag", d, 32'h12);
    readReg(8'h20, d); check("R10 underrun cleared", d, 32'h02);
  endtask

  task automatic testChunk();
    logic [31:0] d;
    writeReg(8'h04, 32'h4000_0000);
    push(4'b0111, 24'h3000);
    check("R11 3 below chunk 4", {31'd0, dmaReq}, 32'd0);
    push(4'b0001, 24'h3100);
    check("R11 4 reaches chunk 4", {31'd0, dmaReq}, 32'd1);
    readReg(8'h20, d); check("R11 chunk bit", d, 32'h09);
    writeReg(8'h04, 32'h8000_0000);
    check("R11 4 below chunk 8", {31'd0, dmaReq}, 32'd0);
    writeReg(8'h04, 32'h3000_0000);
    check("R11 odd value acts as 1", {31'd0, dmaReq}, 32'd1);
    readReg(8'h04, d); check("R11 field reads back", d, 32'h3000_0000);
    for (int k = 0; k < 4; k++) readReg(8'h0C, d);
    check("R11 empty no request", {31'd0, dmaReq}, 32'd0);
    writeReg(8'h04, 32'h1000_0000);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    writeReg(8'h14, 32'h10);
    check("R12 masked off", {31'd0, irqOut}, 32'd0);
    readReg(8'h0C, d);
    check("R12 underrun raises irq", {31'd0, irqOut}, 32'd1);
    readReg(8'h20, d);
    check("R12 irq drops after clear", {31'd0, irqOut}, 32'd0);
    writeReg(8'h14, 32'h01);
    push(4'b0001, 24'h4000);
    check("R12 ready raises irq", {31'd0, irqOut}, 32'd1);
    writeReg(8'h18, 32'h01);
    check("R12 disable lowers irq", {31'd0, irqOut}, 32'd0);
    readReg(8'h0C, d); check("R5 tagged word", d, word(0, 24'h4000));
    writeReg(8'h18, 32'h3F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testVersion();
    testMask();
    testOrder();
    testFullOverrun();
    testPartial();
    testUnderrun();
    testChunk();
    testIrq();
    finishRun();
  end

endmodule